// File: doc/BRIEF.md
# Binary Tree Deserializer

This block widens a narrow stream that delivers one word per clock into a wide word. The stream passes through a tree of splitting stages. Each stage splits its incoming stream into an even-sample way and an odd-sample way, and the two ways leave the stage together at half the rate they arrived. Every level of the tree runs at half the rate of the level above it. After log2(RATIO) levels, each input bit has produced RATIO parallel bits. The even-sample subtree of every stage feeds the lower half of that stage's output block, and the odd-sample subtree feeds the upper half.

Each input bit has its own chain of stages. All nodes on one level share a single phase toggle and a single step strobe. These take the place of the divided clock that a circuit-level build would use, so the whole tree runs on one clock. When a complete group of RATIO samples has been assembled, a one-cycle `out_valid` pulse marks it. The wide word then holds steady until the next pulse. RATIO must be a power of two, and OUT_W must be a multiple of RATIO that is at least RATIO. Any other setting stops elaboration. When RATIO is 1, the block is a plain wire.

Top module: `tree_deser`

## Requirements
- R1: The input width is OUT_W/RATIO. The samples of input bit i land only in `out_data[i*RATIO +: RATIO]`.
- R2: While `rst` is high and in the cycle after it, `out_data` is all zeros and `out_valid` is low.
- R3: `out_valid` is a single-cycle pulse that repeats exactly every RATIO cycles while the stream runs.
- R4: Count the first cycle with `rst` low as cycle 0. The first `out_valid` pulse appears in cycle RATIO-1+log2(RATIO).
- R5: Number the samples of a group k = 0..RATIO-1 in arrival order. Within its block, sample k is placed at the position whose log2(RATIO)-bit index is k with its bits reversed. As a result, the even samples fill the lower half of the block and the odd samples fill the upper half.
- R6: `out_data` changes only in cycles where `out_valid` is high, and it holds its value otherwise.
- R7: A reset in the middle of a group discards the partial group. The first sample after reset becomes sample 0 of a new group.
- R8: With RATIO = 1, `out_data` equals `in_data` in the same cycle, and `out_valid` is the inverse of `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; one input word per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | OUT_W/RATIO | Narrow input word |
| out_valid | output | 1 | One-cycle pulse when a full group is on `out_data` |
| out_data | output | OUT_W | Assembled wide word |

## Verification
The hardest case to reach from the ports is a reset that lands partway through a group. At that moment some stage holds a half-filled even slot and the phases on different levels disagree. If anything from that state survived, it would show up only as a displaced bit in a later word. The stimulus therefore stops a run after a count of cycles that is not a multiple of RATIO, applies reset, and restarts with a different data pattern. Walking-one groups make any swap of even and odd positions appear as a single misplaced bit.

// File: rtl/tree_deser_pkg.sv
`timescale 1ns/1ps
package tree_deser_pkg;

  function automatic int ilog2(input int v);
    int n;
    n = 0;
    while ((1 << (n + 1)) <= v) n++;
    return n;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic bit cfg_ok(input int out_w, input int ratio);
    return is_pow2(ratio) && (out_w >= ratio) && ((out_w % ratio) == 0);
  endfunction

  // cycle (counted from the first cycle out of reset) of the first group pulse
  function automatic int first_valid_cycle(input int ratio);
    return ratio - 1 + ilog2(ratio);
  endfunction

endpackage

// File: rtl/split_stage.sv
`timescale 1ns/1ps
module split_stage (
  input  logic clk,
  input  logic rst,
  input  logic take_even,
  input  logic take_odd,
  input  logic d,
  output logic way0,
  output logic way1
);
  // the even sample waits here so both ways update on the same edge
  logic even_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      even_hold <= 1'b0;
      way0      <= 1'b0;
      way1      <= 1'b0;
    end else begin
      if (take_even) even_hold <= d;
      if (take_odd) begin
        way0 <= even_hold;
        way1 <= d;
      end
    end
  end
endmodule

// File: rtl/tree_level.sv
`timescale 1ns/1ps
module tree_level #(
  parameter int NODES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_in,
  input  logic [NODES-1:0]   d_in,
  output logic               step_out,
  output logic [2*NODES-1:0] d_out
);
  // divide-by-two phase shared by every node on this level
  logic phase;
  logic even_evt;
  logic odd_evt;

  assign even_evt = step_in & ~phase;
  assign odd_evt  = step_in &  phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      step_out <= 1'b0;
    end else begin
      if (step_in) phase <= ~phase;
      step_out <= odd_evt;
    end
  end

  for (genvar j = 0; j < NODES; j++) begin : g_node
    split_stage u_split (
      .clk      (clk),
      .rst      (rst),
      .take_even(even_evt),
      .take_odd (odd_evt),
      .d        (d_in[j]),
      .way0     (d_out[2*j]),
      .way1     (d_out[2*j+1])
    );
  end
endmodule

// File: rtl/tree_deser.sv
`timescale 1ns/1ps
module tree_deser import tree_deser_pkg::*; #(
  parameter  int OUT_W = 8,
  parameter  int RATIO = 4,
  localparam int IN_W  = OUT_W / RATIO,
  localparam int LVLS  = ilog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  if (!cfg_ok(OUT_W, RATIO)) begin : g_bad_cfg
    $error("tree_deser: RATIO must be a power of two dividing OUT_W");
  end

  if (RATIO == 1) begin : g_wire
    assign out_data  = in_data;
    assign out_valid = ~rst;
  end else begin : g_tree
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
      localparam int NODES = IN_W << l;
      logic [NODES-1:0]   din;
      logic               vin;
      logic [2*NODES-1:0] dout;
      logic               vout;

      if (l == 0) begin : g_src
        assign din = in_data;
        assign vin = 1'b1;
      end else begin : g_chain
        assign din = g_lvl[l-1].dout;
        assign vin = g_lvl[l-1].vout;
      end

      tree_level #(.NODES(NODES)) u_level (
        .clk     (clk),
        .rst     (rst),
        .step_in (vin),
        .d_in    (din),
        .step_out(vout),
        .d_out   (dout)
      );
    end

    assign out_data  = g_lvl[LVLS-1].dout;
    assign out_valid = g_lvl[LVLS-1].vout;
  end
endmodule

// File: rtl/tree_deser_chk.sv
`timescale 1ns/1ps
module tree_deser_chk import tree_deser_pkg::*; #(
  parameter int OUT_W = 8,
  parameter int RATIO = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  if (RATIO > 1) begin : g_tree_chk
    logic [15:0] gap;
    logic [15:0] since_rst;
    logic        seen;

    always_ff @(posedge clk) begin
      if (rst) begin
        gap       <= '0;
        since_rst <= '0;
        seen      <= 1'b0;
      end else begin
        if (since_rst != 16'hFFFF) since_rst <= since_rst + 16'd1;
        if (out_valid) gap <= 16'd1;
        else if (gap != 16'hFFFF) gap <= gap + 16'd1;
        if (out_valid) seen <= 1'b1;
      end
    end

    a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_data == '0 && !out_valid));

    a_r3_pulse_period: assert property (@(posedge clk) disable iff (rst)
      (seen && out_valid) |-> (gap == 16'(RATIO)));

    a_r3_no_missed_pulse: assert property (@(posedge clk) disable iff (rst)
      seen |-> (gap <= 16'(RATIO)));

    a_r4_first_pulse: assert property (@(posedge clk) disable iff (rst)
      !seen |-> (out_valid == (since_rst == 16'(first_valid_cycle(RATIO)))));

    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));
  end else begin : g_wire_chk
    a_r8_valid_tracks_reset: assert property (@(posedge clk)
      out_valid == !rst);
  end
endmodule

bind tree_deser tree_deser_chk #(.OUT_W(OUT_W), .RATIO(RATIO)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/tb_tree_deser.sv
`timescale 1ns/1ps
module tb_tree_deser;
  localparam int OUT_W = 8;
  localparam int RATIO = 4;
  localparam int IN_W  = OUT_W / RATIO;
  localparam int LV    = 2;
  localparam int FIRST = RATIO - 1 + LV;
  localparam int PW    = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;
  logic [PW-1:0]    p_in = '0;
  logic             p_valid;
  logic [PW-1:0]    p_out;

  always #10 clk = ~clk;

  tree_deser #(.OUT_W(OUT_W), .RATIO(RATIO)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  tree_deser #(.OUT_W(PW), .RATIO(1)) dut_p (
    .clk(clk), .rst(rst), .in_data(p_in), .out_valid(p_valid), .out_data(p_out));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [IN_W-1:0] samp [0:1023];

  // reversed index built one bit at a time, lowest bit first
  function automatic int rev_pos(input int k);
    int p = 0;
    for (int b = 0; b < LV; b++) p = (p << 1) | ((k >> b) & 1);
    return p;
  endfunction

  function automatic logic [OUT_W-1:0] group_word(input int g);
    logic [OUT_W-1:0] w = '0;
    for (int k = 0; k < RATIO; k++)
      for (int i = 0; i < IN_W; i++)
        w[i*RATIO + rev_pos(k)] = samp[g*RATIO + k][i];
    return w;
  endfunction

  function automatic logic [IN_W-1:0] stim(input int mode, input int n);
    case (mode)
      1:       return '1;
      2:       return ((n % RATIO) == ((n / RATIO) % RATIO)) ? '1 : '0;
      3:       return n[0] ? IN_W'('h5555) : IN_W'('hAAAA);
      default: return IN_W'($urandom);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_data = '0;
    repeat (2) @(negedge clk);
    check(out_data == '0, "R2 data in reset", 64'(out_data), 64'd0);
    check(out_valid == 1'b0, "R2 valid in reset", 64'(out_valid), 64'd0);
    check(p_valid == 1'b0, "R8 valid in reset", 64'(p_valid), 64'd0);
  endtask

  // entered at a negedge with rst high; cycle 0 starts now
  task automatic run(input int mode, input int ncyc, input bit after_mid_reset);
    logic [OUT_W-1:0] expd;
    bit exp_v;
    int g;
    rst = 1'b0;
    samp[0] = stim(mode, 0);
    in_data = samp[0];
    for (int n = 1; n < ncyc; n++) begin
      @(negedge clk);
      exp_v = (n >= FIRST) && (((n - FIRST) % RATIO) == 0);
      g = (n >= FIRST) ? (n - FIRST) / RATIO : -1;
      expd = (g < 0) ? '0 : group_word(g);
      if (n <= FIRST)
        check(out_valid == exp_v, "R4 first pulse", 64'(out_valid), 64'(exp_v));
      else
        check(out_valid == exp_v, "R3 pulse spacing", 64'(out_valid), 64'(exp_v));
      if (exp_v) begin
        for (int i = 0; i < IN_W; i++)
          check(out_data[i*RATIO +: RATIO] == expd[i*RATIO +: RATIO], "R1 bit block",
                64'(out_data[i*RATIO +: RATIO]), 64'(expd[i*RATIO +: RATIO]));
        if (after_mid_reset && g == 0)
          check(out_data == expd, "R7 restart group", 64'(out_data), 64'(expd));
        else
          check(out_data == expd, "R5 sample order", 64'(out_data), 64'(expd));
      end else begin
        check(out_data == expd, "R6 hold", 64'(out_data), 64'(expd));
      end
      check(p_valid == 1'b1, "R8 valid", 64'(p_valid), 64'd1);
      samp[n] = stim(mode, n);
      in_data = samp[n];
      p_in = PW'($urandom);
      #1;
      check(p_out == p_in, "R8 pass-through", 64'(p_out), 64'(p_in));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    run(2, 40, 1'b0);
    do_reset();
    run(0, 300, 1'b0);
    do_reset();
    run(3, 40, 1'b0);
    do_reset();
    run(1, 13, 1'b0);
    do_reset();
    run(2, 60, 1'b1);
    do_reset();
    run(0, 200, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule